// File: doc/BRIEF.md
# SD Host Interrupt Status and Enable Unit

This block keeps the interrupt state of an SD host controller. It holds a 32-bit status register, a 32-bit enable register and a small DMA error code register. It also drives one level-sensitive interrupt line. The transfer and command logic report events as single-cycle pulses on a 32-bit event vector, one wire per status bit. Each pulse latches its status bit.

Software clears status bits by writing ones into them, a byte lane at a time. It rewrites the enable register byte by byte. A software reset byte can clear one of two groups of status bits, or wipe all of the interrupt state.

The interrupt line is combinational from the two registers. It therefore follows any register update in the cycle right after the clock edge that made the update.

Top module: `sd_irq_ctrl`

## Requirements
- R1: `irq` is 1 exactly when some bit is 1 in both `int_status` and `int_enable`. It reflects the registers as updated at the most recent clock edge.
- R2: On `sts_wr`, each status bit whose byte lane (`wr_be[i]` covers bits 8i+7:8i) is enabled and whose `wr_data` bit is 1 is cleared. Bits written with 0, or in disabled lanes, keep their value.
- R3: On `ena_wr`, each byte of `int_enable` whose lane enable is 1 takes the matching byte of `wr_data`. Bytes with the lane enable at 0 keep their value.
- R4: Only these status bits exist: 0 command done, 1 transfer done, 3 DMA end, 4 write buffer ready, 5 read buffer ready, 6 card inserted, 7 card removed, 8 card interrupt, 15 error summary, 16 command timeout, 17 command CRC, 18 command end bit, 19 command index, 20 data timeout, 21 data CRC, 22 data end bit, 23 bus power, 24 auto stop error, 25 descriptor DMA error. All other status bits always read 0, whatever the event input is (implemented mask 0x03FF81FB).
- R5: A reset byte write (`srst_wr`) with `srst[1]` set clears status bit 0 and no other bit.
- R6: A reset byte write with `srst[2]` set clears status bits 1 and 3 and zeroes `dma_err`.
- R7: A reset byte write with `srst[0]` set zeroes `int_status`, `int_enable` and `dma_err`. An enable write in the same cycle is discarded.
- R8: An event pulse on a bit in the same cycle as any clear of that bit (write-one-to-clear or any reset byte) leaves the bit set.
- R9: A status bit latches even while its enable bit is 0. Setting the enable bit later raises `irq` in the cycle after the enable write.
- R10: `dma_err_wr` loads `dma_err_code` into `dma_err`. It takes priority over a data reset or full reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 32 | Single-cycle event pulses, one per status bit |
| sts_wr | input | 1 | Write-one-to-clear strobe for the status register |
| ena_wr | input | 1 | Write strobe for the enable register |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte lane enables for writes |
| srst_wr | input | 1 | Software reset byte strobe |
| srst | input | 8 | Software reset byte: bit 0 full, bit 1 command, bit 2 data |
| dma_err_wr | input | 1 | Load strobe for the DMA error code |
| dma_err_code | input | 2 | DMA error code to load |
| int_status | output | 32 | Status register |
| int_enable | output | 32 | Enable register |
| dma_err | output | 2 | DMA error code register |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives an event, a clear and a reset into the same bit in one cycle. A design that let the clear win would lose the event silently.

It writes with only some byte lanes enabled. A design that ignored `wr_be` would clear or overwrite bytes that software never addressed.

It latches a status bit with its enable off, then turns the enable on. A design that gated latching by the enable would never raise `irq`.

It pulses all 32 event wires and checks that only the implemented bits appear. It also checks that each group reset leaves the bits of the other group alone. Finally, it checks that a full reset drops an enable write made in the same cycle.

// File: rtl/sd_irq_ctrl.sv
module sd_irq_ctrl #(
  parameter int ERR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      evt,
  input  logic             sts_wr,
  input  logic             ena_wr,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  input  logic             srst_wr,
  input  logic [7:0]       srst,
  input  logic             dma_err_wr,
  input  logic [ERR_W-1:0] dma_err_code,
  output logic [31:0]      int_status,
  output logic [31:0]      int_enable,
  output logic [ERR_W-1:0] dma_err,
  output logic             irq
);
  localparam logic [31:0] IMPL     = 32'h03FF_81FB;
  localparam logic [31:0] CMD_GRP  = 32'h0000_0001;
  localparam logic [31:0] DATA_GRP = 32'h0000_000A;

  logic [31:0] lane_mask, clr, set;
  logic        full_rst, cmd_rst, data_rst;

  always_comb begin
    for (int i = 0; i < 4; i++) lane_mask[i*8 +: 8] = {8{wr_be[i]}};
  end

  assign full_rst = srst_wr & srst[0];
  assign cmd_rst  = srst_wr & srst[1];
  assign data_rst = srst_wr & srst[2];
  assign set      = evt & IMPL;
  assign clr      = ({32{sts_wr}} & wr_data & lane_mask)
                  | ({32{cmd_rst}} & CMD_GRP)
                  | ({32{data_rst}} & DATA_GRP)
                  | {32{full_rst}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_status <= '0;
      int_enable <= '0;
      dma_err    <= '0;
    end else begin
      int_status <= (int_status & ~clr) | set;
      if (full_rst)
        int_enable <= '0;
      else if (ena_wr)
        int_enable <= (int_enable & ~lane_mask) | (wr_data & lane_mask);
      if (dma_err_wr)
        dma_err <= dma_err_code;
      else if (full_rst || data_rst)
        dma_err <= '0;
    end
  end

  assign irq = |(int_status & int_enable);
endmodule

module sd_irq_ctrl_chk #(
  parameter int ERR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      evt,
  input logic             sts_wr,
  input logic             ena_wr,
  input logic             srst_wr,
  input logic [7:0]       srst,
  input logic             dma_err_wr,
  input logic [31:0]      int_status,
  input logic [31:0]      int_enable,
  input logic [ERR_W-1:0] dma_err,
  input logic             irq
);
  localparam logic [31:0] IMPL = 32'h03FF_81FB;

  AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & IMPL & int_enable) && !(srst_wr && srst[0]) && !ena_wr) |=> irq); // R1

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr && !srst_wr) |=> ((int_status & $past(int_status)) == $past(int_status))); // R2

  AST_ENA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena_wr && !srst_wr) |=> $stable(int_enable)); // R3

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int_status & ~IMPL) == 32'h0); // R4

  AST_DATA_RST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_wr && srst[2] && !dma_err_wr) |=> (dma_err == '0)); // R6

  AST_FULL_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_wr && srst[0] && evt == 32'h0) |=> (int_status == 32'h0 && int_enable == 32'h0)); // R7

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_status & $past(evt & IMPL)) == $past(evt & IMPL))); // R8
endmodule

bind sd_irq_ctrl sd_irq_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .sts_wr(sts_wr), .ena_wr(ena_wr),
  .srst_wr(srst_wr), .srst(srst), .dma_err_wr(dma_err_wr),
  .int_status(int_status), .int_enable(int_enable), .dma_err(dma_err), .irq(irq)
);

// File: tb/sd_irq_ctrl_tb.sv
module sd_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] IMPL = 32'h03FF_81FB;

  logic        clk = 0, rst_n = 0;
  logic [31:0] evt = 0, wr_data = 0;
  logic        sts_wr = 0, ena_wr = 0, srst_wr = 0, dma_err_wr = 0;
  logic [3:0]  wr_be = 0;
  logic [7:0]  srst = 0;
  logic [1:0]  dma_err_code = 0;
  logic [31:0] int_status, int_enable;
  logic [1:0]  dma_err;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sd_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sts_wr(sts_wr), .ena_wr(ena_wr),
    .wr_data(wr_data), .wr_be(wr_be), .srst_wr(srst_wr), .srst(srst),
    .dma_err_wr(dma_err_wr), .dma_err_code(dma_err_code),
    .int_status(int_status), .int_enable(int_enable), .dma_err(dma_err), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt = 0; sts_wr = 0; ena_wr = 0; srst_wr = 0; dma_err_wr = 0;
    wr_data = 0; wr_be = 0; srst = 0; dma_err_code = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic pulse(logic [31:0] e);
    evt = e; step();
  endtask

  task automatic w_sts(logic [31:0] d, logic [3:0] be);
    sts_wr = 1; wr_data = d; wr_be = be; step();
  endtask

  task automatic w_ena(logic [31:0] d, logic [3:0] be);
    ena_wr = 1; wr_data = d; wr_be = be; step();
  endtask

  task automatic w_srst(logic [7:0] b);
    srst_wr = 1; srst = b; step();
  endtask

  task automatic clear_all();
    w_srst(8'h01);
  endtask

  task automatic t_reset();
    chk("R7 reset status", int_status, 0);
    chk("R7 reset enable", int_enable, 0);
    chk("R1 reset irq", {31'b0, irq}, 0);
    chk("R10 reset dma_err", {30'b0, dma_err}, 0);
  endtask

  task automatic t_latch();
    pulse(32'h20);
    chk("R9 latched with enable off", int_status, 32'h20);
    chk("R9 no irq while disabled", {31'b0, irq}, 0);
    w_ena(32'h20, 4'b0001);
    chk("R9 irq after enabling", {31'b0, irq}, 1);
    pulse(32'hFFFF_FFFF);
    chk("R4 only implemented bits", int_status, IMPL);
  endtask

  task automatic t_w1c();
    w_sts(32'hFFFF_FFFF, 4'b0010);
    chk("R2 lane 1 clear", int_status, IMPL & ~32'h0000_FF00);
    w_sts(32'h0000_0003, 4'b1111);
    chk("R2 ones clear", int_status, IMPL & ~32'h0000_FF03);
    w_sts(32'h0000_0000, 4'b1111);
    chk("R2 zeros keep", int_status, IMPL & ~32'h0000_FF03);
    w_sts(32'h0300_0000, 4'b0111);
    chk("R2 disabled lane keeps", int_status, IMPL & ~32'h0000_FF03);
  endtask

  task automatic t_enable();
    clear_all();
    w_ena(32'hAABB_CCDD, 4'b1111);
    chk("R3 full write", int_enable, 32'hAABB_CCDD);
    w_ena(32'h1122_3344, 4'b0101);
    chk("R3 partial write", int_enable, 32'hAA22_CC44);
  endtask

  task automatic t_irq();
    clear_all();
    w_ena(32'h0000_0002, 4'b1111);
    pulse(32'h0001_0000);
    chk("R1 masked event no irq", {31'b0, irq}, 0);
    pulse(32'h0000_0002);
    chk("R1 enabled event irq", {31'b0, irq}, 1);
    w_sts(32'h0000_0002, 4'b0001);
    chk("R1 irq drops after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_cmd_rst();
    clear_all();
    pulse(32'h0001_000B);
    w_srst(8'h02);
    chk("R5 command reset", int_status, 32'h0001_000A);
  endtask

  task automatic t_data_rst();
    clear_all();
    dma_err_wr = 1; dma_err_code = 2'b10; step();
    chk("R10 dma_err load", {30'b0, dma_err}, 2);
    pulse(32'h0001_000B);
    w_srst(8'h04);
    chk("R6 data reset status", int_status, 32'h0001_0001);
    chk("R6 data reset dma_err", {30'b0, dma_err}, 0);
  endtask

  task automatic t_full();
    w_ena(32'hFFFF_FFFF, 4'b1111);
    pulse(32'h0000_0F00);
    dma_err_wr = 1; dma_err_code = 2'b01; step();
    srst_wr = 1; srst = 8'h01; ena_wr = 1; wr_data = 32'h1234_5678; wr_be = 4'hF; step();
    chk("R7 full reset status", int_status, 0);
    chk("R7 full reset enable", int_enable, 0);
    chk("R7 full reset dma_err", {30'b0, dma_err}, 0);
  endtask

  task automatic t_evt_wins();
    clear_all();
    pulse(32'h1);
    evt = 32'h1; sts_wr = 1; wr_data = 32'h1; wr_be = 4'hF; step();
    chk("R8 event beats w1c", int_status, 32'h1);
    evt = 32'h1; srst_wr = 1; srst = 8'h02; step();
    chk("R8 event beats command reset", int_status, 32'h1);
    w_ena(32'hFF, 4'b0001);
    evt = 32'h40; srst_wr = 1; srst = 8'h01; step();
    chk("R8 event beats full reset", int_status, 32'h40);
    chk("R7 enable cleared by full reset", int_enable, 0);
  endtask

  task automatic t_dma_err();
    dma_err_wr = 1; dma_err_code = 2'b11; srst_wr = 1; srst = 8'h04; step();
    chk("R10 load beats data reset", {30'b0, dma_err}, 3);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_w1c();
    t_enable();
    t_irq();
    t_cmd_rst();
    t_data_rst();
    t_full();
    t_evt_wins();
    t_dma_err();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule